// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores sixty-four 32-bit register words for a floating-point unit and moves them as raw bit patterns, with no arithmetic and no format conversion. A 32-bit mode register steers every access. One of its bits picks which group of sixteen words is the active bank. A second bit widens the move view to 64 bits. A third bit turns the precision view into a double view.

A combinational read port and a synchronous write port each take a 3-bit access kind and a 6-bit index. The kind picks one of several views: one word of the active bank, one word of the inactive bank, a pair of words joined into a 64-bit double in either bank, the precision-steered view, or the move view. Doubles put the lower-numbered word in the upper half of the 64-bit bus. A pair with an odd base is refused. Refusal raises an illegal flag, forces read data to zero and blocks the write. The mode register has its own full-word write and a single-bit write that changes one mode bit and leaves the rest alone.

Top module: `fpr_bank_file`

## Requirements
- R1: After reset the mode register reads 0 and every stored word is 0.
- R2: A full mode write loads `ctl_wdata`. A bit write changes only one bit of the mode register: `bit_sel` 0 selects the bank bit (bit 21), 1 the size bit (bit 20), 2 the precision bit (bit 19), and 3 changes nothing. When both writes occur in one cycle, the bit write wins for its own bit.
- R3: Kind 0 (active single) reaches physical word (16*bank + idx) mod 64. A read returns that word in bits 31:0 with bits 63:32 zero. A write stores only `wr_data[31:0]`.
- R4: Kind 1 (inactive single) reaches physical word (16*(1-bank) + idx) mod 64, which is always the bank that is not selected.
- R5: Kind 2 (active double) and kind 3 (inactive double) first apply the same bank offset as kinds 0 and 1. Word base+idx then forms bits 63:32 and word base+idx+1 forms bits 31:0. A double write splits the value back into those two words.
- R6: Kind 4 (precision view) acts as kind 2 when the precision bit is 1 and as kind 0 when it is 0.
- R7: Kind 5 (move view) acts as kind 0 when the size bit is 0.
- R8: Kind 5 with the size bit set acts as kind 2 for an even index. For an odd index it acts as kind 3 at the index with bit 0 cleared, and that case is never illegal.
- R9: An odd index on kind 2, kind 3, or kind 4 with precision set is illegal. Kinds 6 and 7 are always illegal. An illegal read drives `rd_illegal` high and `rd_data` to 0. An illegal write drives `wr_illegal` high and leaves every word unchanged.
- R10: Writes take effect at the clock edge and reads are combinational. A write uses the mode bits held before that edge, so a bank change made in the same cycle affects only the accesses that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_kind | input | 3 | Read access kind |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read data (single words in bits 31:0) |
| rd_illegal | output | 1 | Read access refused |
| wr_en | input | 1 | Write request |
| wr_kind | input | 3 | Write access kind |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| wr_illegal | output | 1 | Write access refused (write suppressed) |
| ctl_wr_en | input | 1 | Full mode register write |
| ctl_wdata | input | 32 | Full mode register value |
| bit_wr_en | input | 1 | Single mode-bit write |
| bit_sel | input | 2 | Which mode bit to write |
| bit_val | input | 1 | New value for the selected mode bit |
| ctl_rdata | output | 32 | Mode register contents |

## Verification
The bench builds the block with its default parameters: 32-bit words, 64 words, and a bank stride of 16. With these values a 6-bit index added to the bank offset wraps past word 63. For example, index 63 in bank 1 lands on word 15, which bank 0 reaches by two other routes, so the modulo rule is observable at the ports. The same values leave words 16 to 31 as the inactive bank of bank 0. That lets the bench check the inactive-bank doubles and the odd-index move reinterpretation against words it wrote through other views.

// File: rtl/fpr_bank_pkg.sv
package fpr_bank_pkg;

    typedef enum logic [2:0] {
        KIND_SGL_ACT  = 3'd0,
        KIND_SGL_INA  = 3'd1,
        KIND_DBL_ACT  = 3'd2,
        KIND_DBL_INA  = 3'd3,
        KIND_PREC     = 3'd4,
        KIND_MOVE     = 3'd5,
        KIND_RSV6     = 3'd6,
        KIND_RSV7     = 3'd7
    } access_kind_e;

    typedef enum logic [1:0] {
        SEL_BANK = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_PREC = 2'd2,
        SEL_NONE = 2'd3
    } mode_sel_e;

    localparam int MODE_W   = 32;
    localparam int BANK_POS = 21;
    localparam int SIZE_POS = 20;
    localparam int PREC_POS = 19;

    function automatic logic [MODE_W-1:0] mode_mask(input logic [1:0] sel);
        logic [MODE_W-1:0] m;
        m = '0;
        case (sel)
            2'd0:    m[BANK_POS] = 1'b1;
            2'd1:    m[SIZE_POS] = 1'b1;
            2'd2:    m[PREC_POS] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpr_mode_reg.sv
module fpr_mode_reg
    import fpr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [MODE_W-1:0] ctl_wdata,
    input  logic              bit_wr_en,
    input  logic [1:0]        bit_sel,
    input  logic              bit_val,
    output logic [MODE_W-1:0] mode_q,
    output logic              bank_q,
    output logic              size_q,
    output logic              prec_q
);

    logic [MODE_W-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (ctl_wr_en) begin
            mode_d = ctl_wdata;
        end
        if (bit_wr_en) begin
            unique case (mode_sel_e'(bit_sel))
                SEL_BANK: mode_d[BANK_POS] = bit_val;
                SEL_SIZE: mode_d[SIZE_POS] = bit_val;
                SEL_PREC: mode_d[PREC_POS] = bit_val;
                SEL_NONE: mode_d = mode_d;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign bank_q = mode_q[BANK_POS];
    assign size_q = mode_q[SIZE_POS];
    assign prec_q = mode_q[PREC_POS];

endmodule

// File: rtl/fpr_access_map.sv
module fpr_access_map
    import fpr_bank_pkg::*;
#(
    parameter int NUM_WORDS   = 64,
    parameter int BANK_STRIDE = 16,
    localparam int IDX_W      = $clog2(NUM_WORDS)
) (
    input  logic [2:0]       kind,
    input  logic [IDX_W-1:0] idx,
    input  logic             bank,
    input  logic             size,
    input  logic             prec,
    output logic             dbl,
    output logic [IDX_W-1:0] word_a,
    output logic [IDX_W-1:0] word_b,
    output logic             illegal
);

    localparam logic [IDX_W-1:0] STRIDE = IDX_W'(BANK_STRIDE);

    logic             use_ina;
    logic [IDX_W-1:0] eff_idx;
    logic [IDX_W-1:0] offset;

    always_comb begin
        dbl     = 1'b0;
        use_ina = 1'b0;
        illegal = 1'b0;
        eff_idx = idx;
        unique case (access_kind_e'(kind))
            KIND_SGL_ACT: begin
                dbl = 1'b0;
            end
            KIND_SGL_INA: begin
                use_ina = 1'b1;
            end
            KIND_DBL_ACT: begin
                dbl     = 1'b1;
                illegal = idx[0];
            end
            KIND_DBL_INA: begin
                dbl     = 1'b1;
                use_ina = 1'b1;
                illegal = idx[0];
            end
            KIND_PREC: begin
                dbl     = prec;
                illegal = prec & idx[0];
            end
            KIND_MOVE: begin
                if (size) begin
                    dbl        = 1'b1;
                    use_ina    = idx[0];
                    eff_idx[0] = 1'b0;
                end
            end
            KIND_RSV6, KIND_RSV7: begin
                illegal = 1'b1;
            end
        endcase
    end

    // active bank offset is stride*bank, inactive is stride*(~bank)
    assign offset = ((bank ^ use_ina) ? STRIDE : '0);
    assign word_a = offset + eff_idx;
    assign word_b = word_a + IDX_W'(1);

endmodule

// File: rtl/fpr_word_store.sv
module fpr_word_store #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 64,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_a,
    input  logic [IDX_W-1:0]                  wa,
    input  logic [WORD_W-1:0]                 da,
    input  logic                              we_b,
    input  logic [IDX_W-1:0]                  wb,
    input  logic [WORD_W-1:0]                 db,
    input  logic [IDX_W-1:0]                  ra,
    input  logic [IDX_W-1:0]                  rb,
    output logic [WORD_W-1:0]                 qa,
    output logic [WORD_W-1:0]                 qb,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(k);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[k] <= '0;
            end else if (we_a && wa == MY_IDX) begin
                words[k] <= da;
            end else if (we_b && wb == MY_IDX) begin
                words[k] <= db;
            end
        end
    end

    assign qa = words[ra];
    assign qb = words[rb];

endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file
    import fpr_bank_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int NUM_WORDS   = 64,
    parameter int BANK_STRIDE = 16,
    localparam int IDX_W      = $clog2(NUM_WORDS),
    localparam int DATA_W     = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rd_kind,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_illegal,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic              ctl_wr_en,
    input  logic [MODE_W-1:0] ctl_wdata,
    input  logic              bit_wr_en,
    input  logic [1:0]        bit_sel,
    input  logic              bit_val,
    output logic [MODE_W-1:0] ctl_rdata
);

    logic bank, size, prec;

    logic             rd_dbl, wr_dbl;
    logic [IDX_W-1:0] rd_a, rd_b, wr_a, wr_b;
    logic [WORD_W-1:0] q_a, q_b;
    logic             we_a, we_b;
    logic [WORD_W-1:0] d_a;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words_all;

    fpr_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr_en (ctl_wr_en),
        .ctl_wdata (ctl_wdata),
        .bit_wr_en (bit_wr_en),
        .bit_sel   (bit_sel),
        .bit_val   (bit_val),
        .mode_q    (ctl_rdata),
        .bank_q    (bank),
        .size_q    (size),
        .prec_q    (prec)
    );

    fpr_access_map #(
        .NUM_WORDS   (NUM_WORDS),
        .BANK_STRIDE (BANK_STRIDE)
    ) u_rd_map (
        .kind    (rd_kind),
        .idx     (rd_idx),
        .bank    (bank),
        .size    (size),
        .prec    (prec),
        .dbl     (rd_dbl),
        .word_a  (rd_a),
        .word_b  (rd_b),
        .illegal (rd_illegal)
    );

    fpr_access_map #(
        .NUM_WORDS   (NUM_WORDS),
        .BANK_STRIDE (BANK_STRIDE)
    ) u_wr_map (
        .kind    (wr_kind),
        .idx     (wr_idx),
        .bank    (bank),
        .size    (size),
        .prec    (prec),
        .dbl     (wr_dbl),
        .word_a  (wr_a),
        .word_b  (wr_b),
        .illegal (wr_illegal)
    );

    assign we_a = wr_en & ~wr_illegal;
    assign we_b = we_a & wr_dbl;
    assign d_a  = wr_dbl ? wr_data[DATA_W-1:WORD_W] : wr_data[WORD_W-1:0];

    fpr_word_store #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_a  (we_a),
        .wa    (wr_a),
        .da    (d_a),
        .we_b  (we_b),
        .wb    (wr_b),
        .db    (wr_data[WORD_W-1:0]),
        .ra    (rd_a),
        .rb    (rd_b),
        .qa    (q_a),
        .qb    (q_b),
        .words (words_all)
    );

    always_comb begin
        if (rd_illegal) begin
            rd_data = '0;
        end else if (rd_dbl) begin
            rd_data = {q_a, q_b};
        end else begin
            rd_data = {{WORD_W{1'b0}}, q_a};
        end
    end

endmodule

// File: rtl/fpr_bank_file_chk.sv
module fpr_bank_file_chk
    import fpr_bank_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 64
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [2:0]                       rd_kind,
    input logic [2*WORD_W-1:0]              rd_data,
    input logic                             rd_illegal,
    input logic                             wr_en,
    input logic                             wr_illegal,
    input logic                             ctl_wr_en,
    input logic                             bit_wr_en,
    input logic [1:0]                       bit_sel,
    input logic                             bit_val,
    input logic [MODE_W-1:0]                ctl_rdata,
    input logic [NUM_WORDS-1:0][WORD_W-1:0] words_all
);

    logic [MODE_W-1:0] sel_mask;
    assign sel_mask = mode_mask(bit_sel);

    // R2: a lone bit write touches no other mode bit
    assert_bit_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && !ctl_wr_en) |=>
            (((ctl_rdata ^ $past(ctl_rdata)) & ~$past(sel_mask)) == '0));

    // R2: the bank bit takes the written value
    assert_bank_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && bit_sel == 2'd0) |=> (ctl_rdata[BANK_POS] == $past(bit_val)));

    // R3: single-word reads leave the upper half at zero
    assert_single_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == 3'd0 || rd_kind == 3'd1) |-> (rd_data[2*WORD_W-1:WORD_W] == '0));

    // R9: an illegal read returns zero
    assert_illegal_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    // R9: an illegal write leaves storage untouched
    assert_illegal_write_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_illegal) |=> $stable(words_all));

    // R10: storage changes only through a write request
    assert_no_write_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words_all));

endmodule

bind fpr_bank_file fpr_bank_file_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_kind    (rd_kind),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .wr_en      (wr_en),
    .wr_illegal (wr_illegal),
    .ctl_wr_en  (ctl_wr_en),
    .bit_wr_en  (bit_wr_en),
    .bit_sel    (bit_sel),
    .bit_val    (bit_val),
    .ctl_rdata  (ctl_rdata),
    .words_all  (words_all)
);

// File: tb/fpr_bank_file_tb.sv
module fpr_bank_file_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_SA = 3'd0, K_SI = 3'd1, K_DA = 3'd2, K_DI = 3'd3,
                           K_PR = 3'd4, K_MV = 3'd5, K_R6 = 3'd6, K_R7 = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_kind = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_illegal;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        bit_wr_en = 1'b0;
    logic [1:0]  bit_sel = '0;
    logic        bit_val = 1'b0;
    logic [31:0] ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpr_bank_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data), .rd_illegal(rd_illegal),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
        .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
        .ctl_rdata(ctl_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [2:0] k, input logic [5:0] i, input logic [63:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_bit(input logic [1:0] s, input logic v);
        bit_wr_en = 1'b1; bit_sel = s; bit_val = v;
        step();
        bit_wr_en = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [2:0] k, input logic [5:0] i,
                             input logic [63:0] d, input logic ill);
        rd_kind = k; rd_idx = i;
        #1;
        check(req, rd_data, d);
        check(req, {63'd0, rd_illegal}, {63'd0, ill});
    endtask

    task automatic t_reset();
        check("R1 mode", {32'd0, ctl_rdata}, 64'd0);
        expect_rd("R1 word0", K_SA, 6'd0, 64'd0, 1'b0);
        expect_rd("R1 ina dbl", K_DI, 6'd8, 64'd0, 1'b0);
    endtask

    task automatic t_mode();
        ctl_wr_en = 1'b1; ctl_wdata = 32'h0000_1234;
        step();
        ctl_wr_en = 1'b0;
        check("R2 full write", {32'd0, ctl_rdata}, 64'h0000_1234);
        set_bit(2'd0, 1'b1);
        check("R2 bank bit", {32'd0, ctl_rdata}, 64'h0020_1234);
        set_bit(2'd1, 1'b1);
        check("R2 size bit", {32'd0, ctl_rdata}, 64'h0030_1234);
        set_bit(2'd2, 1'b1);
        check("R2 prec bit", {32'd0, ctl_rdata}, 64'h0038_1234);
        set_bit(2'd3, 1'b1);
        check("R2 sel3 no effect", {32'd0, ctl_rdata}, 64'h0038_1234);
        set_bit(2'd0, 1'b0);
        check("R2 bank clear", {32'd0, ctl_rdata}, 64'h0018_1234);
        ctl_wr_en = 1'b1; ctl_wdata = 32'hFFFF_FFFF;
        bit_wr_en = 1'b1; bit_sel = 2'd2; bit_val = 1'b0;
        step();
        ctl_wr_en = 1'b0; bit_wr_en = 1'b0;
        check("R2 bit wins", {32'd0, ctl_rdata}, 64'hFFF7_FFFF);
        ctl_wr_en = 1'b1; ctl_wdata = 32'h0;
        step();
        ctl_wr_en = 1'b0;
    endtask

    task automatic t_single();
        do_write(K_SA, 6'd3, 64'hDEAD_BEEF_1111_1111);
        expect_rd("R3 active single", K_SA, 6'd3, 64'h1111_1111, 1'b0);
        expect_rd("R4 inactive empty", K_SI, 6'd3, 64'd0, 1'b0);
        do_write(K_SI, 6'd3, 64'h0000_0000_2222_2222);
        set_bit(2'd0, 1'b1);
        expect_rd("R3 bank1 active", K_SA, 6'd3, 64'h2222_2222, 1'b0);
        expect_rd("R4 bank1 inactive", K_SI, 6'd3, 64'h1111_1111, 1'b0);
        do_write(K_SA, 6'd63, 64'h0000_0000_3333_3333);
        set_bit(2'd0, 1'b0);
        expect_rd("R3 wrap", K_SA, 6'd15, 64'h3333_3333, 1'b0);
        expect_rd("R4 wrap", K_SI, 6'd63, 64'h3333_3333, 1'b0);
    endtask

    task automatic t_double();
        do_write(K_DA, 6'd4, 64'hAAAA_0001_BBBB_0002);
        expect_rd("R5 hi word", K_SA, 6'd4, 64'hAAAA_0001, 1'b0);
        expect_rd("R5 lo word", K_SA, 6'd5, 64'hBBBB_0002, 1'b0);
        expect_rd("R5 active dbl", K_DA, 6'd4, 64'hAAAA_0001_BBBB_0002, 1'b0);
        do_write(K_DI, 6'd6, 64'hCCCC_0003_DDDD_0004);
        expect_rd("R5 ina hi", K_SI, 6'd6, 64'hCCCC_0003, 1'b0);
        expect_rd("R5 ina lo", K_SI, 6'd7, 64'hDDDD_0004, 1'b0);
        set_bit(2'd0, 1'b1);
        expect_rd("R5 bank1 active dbl", K_DA, 6'd6, 64'hCCCC_0003_DDDD_0004, 1'b0);
        expect_rd("R5 bank1 ina dbl", K_DI, 6'd4, 64'hAAAA_0001_BBBB_0002, 1'b0);
        set_bit(2'd0, 1'b0);
    endtask

    task automatic t_prec();
        expect_rd("R6 prec0 single", K_PR, 6'd4, 64'hAAAA_0001, 1'b0);
        do_write(K_PR, 6'd10, 64'h5555_6666_7777_8888);
        expect_rd("R6 prec0 write", K_SA, 6'd10, 64'h7777_8888, 1'b0);
        expect_rd("R6 prec0 no pair", K_SA, 6'd11, 64'd0, 1'b0);
        set_bit(2'd2, 1'b1);
        expect_rd("R6 prec1 double", K_PR, 6'd4, 64'hAAAA_0001_BBBB_0002, 1'b0);
        do_write(K_PR, 6'd12, 64'h1212_3434_5656_7878);
        expect_rd("R6 prec1 lo", K_SA, 6'd13, 64'h5656_7878, 1'b0);
        set_bit(2'd2, 1'b0);
    endtask

    task automatic t_move();
        expect_rd("R7 size0 read", K_MV, 6'd4, 64'hAAAA_0001, 1'b0);
        do_write(K_MV, 6'd8, 64'hFFFF_FFFF_9999_0000);
        expect_rd("R7 size0 write", K_SA, 6'd8, 64'h9999_0000, 1'b0);
        expect_rd("R7 size0 no pair", K_SA, 6'd9, 64'd0, 1'b0);
        set_bit(2'd1, 1'b1);
        expect_rd("R8 even", K_MV, 6'd4, 64'hAAAA_0001_BBBB_0002, 1'b0);
        expect_rd("R8 odd", K_MV, 6'd7, 64'hCCCC_0003_DDDD_0004, 1'b0);
        do_write(K_MV, 6'd9, 64'h0A0A_0B0B_0C0C_0D0D);
        expect_rd("R8 odd write hi", K_SI, 6'd8, 64'h0A0A_0B0B, 1'b0);
        expect_rd("R8 odd write lo", K_SI, 6'd9, 64'h0C0C_0D0D, 1'b0);
        expect_rd("R8 active kept", K_SA, 6'd8, 64'h9999_0000, 1'b0);
        set_bit(2'd0, 1'b1);
        expect_rd("R8 odd follows bank", K_MV, 6'd5, 64'hAAAA_0001_BBBB_0002, 1'b0);
        set_bit(2'd0, 1'b0);
        set_bit(2'd1, 1'b0);
    endtask

    task automatic t_illegal();
        expect_rd("R9 odd active dbl", K_DA, 6'd5, 64'd0, 1'b1);
        wr_en = 1'b1; wr_kind = K_DA; wr_idx = 6'd5; wr_data = '1;
        #1;
        check("R9 wr flag", {63'd0, wr_illegal}, 64'd1);
        step();
        wr_en = 1'b0;
        expect_rd("R9 write blocked a", K_SA, 6'd5, 64'hBBBB_0002, 1'b0);
        expect_rd("R9 write blocked b", K_SA, 6'd6, 64'd0, 1'b0);
        expect_rd("R9 odd ina dbl", K_DI, 6'd3, 64'd0, 1'b1);
        expect_rd("R9 prec0 odd ok", K_PR, 6'd3, 64'h1111_1111, 1'b0);
        set_bit(2'd2, 1'b1);
        expect_rd("R9 prec1 odd", K_PR, 6'd3, 64'd0, 1'b1);
        set_bit(2'd2, 1'b0);
        expect_rd("R9 kind6", K_R6, 6'd4, 64'd0, 1'b1);
        do_write(K_R7, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_rd("R9 kind7 blocked", K_SA, 6'd0, 64'd0, 1'b0);
    endtask

    task automatic t_timing();
        rd_kind = K_SA; rd_idx = 6'd1;
        wr_en = 1'b1; wr_kind = K_SA; wr_idx = 6'd1; wr_data = 64'h4444_4444;
        bit_wr_en = 1'b1; bit_sel = 2'd0; bit_val = 1'b1;
        #1;
        check("R10 read before edge", rd_data, 64'd0);
        step();
        wr_en = 1'b0; bit_wr_en = 1'b0;
        expect_rd("R10 old bank used", K_SI, 6'd1, 64'h4444_4444, 1'b0);
        expect_rd("R10 new bank active", K_SA, 6'd1, 64'd0, 1'b0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mode();
        t_single();
        t_double();
        t_prec();
        t_move();
        t_illegal();
        t_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule